// File: doc/BRIEF.md
# Privileged Cycle Counters: Time-of-Day and Interval Timer

This block holds two 54-bit counters that advance by one on every clock cycle. The first is a time-of-day clock. The second is an interval timer that produces an expiry pulse when it wraps from all-ones to zero. Either counter can be read at any privilege level. A read returns a 64-bit word that holds the count in bits 53:0, with bits 63:54 always zero. The upper 32-bit half of that word is also given on its own port, for register transfers of a single word.

Writes come in through one port. That port carries a privilege flag and a width flag. A full write comes from a 64-bit memory load and replaces all 54 bits. A high-word write comes from a 32-bit register transfer and replaces only bits 53:32. A write at kernel level takes effect at the next clock edge, in place of that cycle's increment. A write at user level changes nothing and raises a one-cycle privilege-fault pulse. Interrupt delivery and status bits belong to the surrounding logic.

Each cycle, the write request is classified into one of four access states:
- `ACC_IDLE`: no write.
- `ACC_LOAD_FULL`: a kernel full write.
- `ACC_LOAD_HIGH`: a kernel high-word write.
- `ACC_REFUSE`: a user write of either width.

The state follows from the write inputs alone, so any state can go to any other state on the next cycle. `ACC_IDLE` moves to a load state on a kernel write and to `ACC_REFUSE` on a user write. Every state returns to `ACC_IDLE` when `wr_en` is low. A registered fault flag captures `ACC_REFUSE`.

Top module: `chrono_regs`

## Requirements
- R1: After reset, both counters read zero, and `priv_fault` and `timer_expired` are low.
- R2: With no write, each counter reads one more than it did one clock cycle earlier. Both counters advance together.
- R3: `rd_data` holds the counter chosen by `rd_sel` (0 = time-of-day, 1 = interval timer) in bits 53:0, and bits 63:54 read zero. `rd_high_word` equals `rd_data[63:32]`.
- R4: A kernel write (`wr_kernel`=1) with `wr_high`=0 loads `wr_data[53:0]` into the counter chosen by `wr_sel` (0 = time-of-day, 1 = interval timer). The loaded value is read in the cycle after the edge, and no increment is added in that cycle.
- R5: A kernel write with `wr_high`=1 carries the transferred 32-bit word in `wr_data[63:32]`. The low 22 bits of that word, which are `wr_data[53:32]`, replace counter bits 53:32. Counter bits 31:0 keep the value they held before the edge, and the other bits of `wr_data` are ignored.
- R6: A user write (`wr_kernel`=0) of either width leaves the chosen counter counting as if no write had occurred. It raises `priv_fault` for exactly the one cycle after the write edge.
- R7: A write to one counter does not disturb the other counter, which keeps incrementing.
- R8: When the interval timer increments from all-ones to zero, `timer_expired` is high for exactly the one cycle in which the timer reads zero.
- R9: Loading zero into the interval timer does not raise `timer_expired`. A kernel load applied while the timer holds all-ones replaces the wrap, and no expiry pulse follows.
- R10: A wrap of the time-of-day counter never raises `timer_expired`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_sel | input | 1 | Write target: 0 time-of-day, 1 interval timer |
| wr_high | input | 1 | 1 = 32-bit high-word transfer, 0 = full 64-bit load |
| wr_kernel | input | 1 | 1 = kernel privilege, 0 = user |
| wr_data | input | 64 | Write data; high-word transfers use bits 63:32 |
| rd_sel | input | 1 | Read target: 0 time-of-day, 1 interval timer |
| rd_data | output | 64 | Zero-extended count of the selected counter |
| rd_high_word | output | 32 | Upper half of `rd_data` |
| priv_fault | output | 1 | One-cycle pulse after a refused user write |
| timer_expired | output | 1 | One-cycle pulse when the interval timer wraps to zero |

## Verification
The bench loads the interval timer with one less than all-ones and then writes it again exactly as it reaches all-ones. A design that lets the wrap win would show zero and a false expiry pulse here, where it should show the new value. A zero load and a time-of-day wrap must both stay silent, which catches expiry logic that only tests for zero or ignores which counter wrapped. A high-word write with junk in the top transfer bits must leave the low 32 bits frozen at their pre-edge value; a design that increments them, clears them, or takes the junk bits would be caught. User writes of both widths must leave the count running and must give a fault pulse exactly one cycle wide.

// File: rtl/chrono_pkg.sv
package chrono_pkg;
    parameter int CNT_W  = 54;
    parameter int WORD_W = 64;
    parameter int XFER_W = 32;
    parameter int N_CTR  = 2;

    typedef enum logic [1:0] {
        ACC_IDLE      = 2'd0,
        ACC_LOAD_FULL = 2'd1,
        ACC_LOAD_HIGH = 2'd2,
        ACC_REFUSE    = 2'd3
    } acc_t;

    typedef enum logic {
        SEL_TOD = 1'b0,
        SEL_IVT = 1'b1
    } csel_t;
endpackage

// File: rtl/chrono_access.sv
module chrono_access
    import chrono_pkg::*;
(
    input  logic wr_en,
    input  logic wr_kernel,
    input  logic wr_high,
    output acc_t acc
);
    always_comb begin
        acc = ACC_IDLE;
        unique case ({wr_en, wr_kernel, wr_high})
            3'b100, 3'b101: acc = ACC_REFUSE;
            3'b110:         acc = ACC_LOAD_FULL;
            3'b111:         acc = ACC_LOAD_HIGH;
            default:        acc = ACC_IDLE;
        endcase
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W      = 54,
    parameter int XFER_W     = 32,
    parameter bit HAS_EXPIRY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_full,
    input  logic             load_high,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);
    logic [CNT_W-1:0] nxt;
    logic             wrap;

    always_comb begin
        if (load_full)
            nxt = load_val;
        else if (load_high)
            nxt = {load_val[CNT_W-1:XFER_W], cnt[XFER_W-1:0]};
        else
            nxt = cnt + 1'b1;
    end

    assign wrap = !load_full && !load_high && (&cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end

    generate
        if (HAS_EXPIRY) begin : g_exp
            logic exp_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) exp_q <= 1'b0;
                else        exp_q <= wrap;
            end
            assign expired = exp_q;

            assert_expiry_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                expired |-> (cnt == '0));
            assert_expiry_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
                expired |=> !expired);
        end else begin : g_noexp
            assign expired = 1'b0;
        end
    endgenerate

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_full && !load_high) |=> (cnt == $past(cnt) + 1'b1));
    assert_full_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_full |=> (cnt == $past(load_val)));
    assert_high_keeps_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_high && !load_full) |=> (cnt[XFER_W-1:0] == $past(cnt[XFER_W-1:0])));
endmodule

// File: rtl/chrono_regs.sv
module chrono_regs
    import chrono_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int WW = WORD_W,
    parameter int XW = XFER_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic          wr_high,
    input  logic          wr_kernel,
    input  logic [WW-1:0] wr_data,
    input  logic          rd_sel,
    output logic [WW-1:0] rd_data,
    output logic [XW-1:0] rd_high_word,
    output logic          priv_fault,
    output logic          timer_expired
);
    localparam int PAD_W = WW - CW;

    acc_t             acc;
    logic [CW-1:0]    cnt_arr [N_CTR];
    logic [N_CTR-1:0] exp_arr;
    logic             fault_q;

    chrono_access u_access (
        .wr_en     (wr_en),
        .wr_kernel (wr_kernel),
        .wr_high   (wr_high),
        .acc       (acc)
    );

    generate
        for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
            logic hit;
            assign hit = (wr_sel == i[0]);
            tick_counter #(
                .CNT_W      (CW),
                .XFER_W     (XW),
                .HAS_EXPIRY (i == int'(SEL_IVT))
            ) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .load_full (hit && (acc == ACC_LOAD_FULL)),
                .load_high (hit && (acc == ACC_LOAD_HIGH)),
                .load_val  (wr_data[CW-1:0]),
                .cnt       (cnt_arr[i]),
                .expired   (exp_arr[i])
            );
        end
    endgenerate

    // fault state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= (acc == ACC_REFUSE);
    end

    // outputs
    always_comb begin
        rd_data       = {{PAD_W{1'b0}}, cnt_arr[rd_sel]};
        rd_high_word  = rd_data[WW-1:WW-XW];
        priv_fault    = fault_q;
        timer_expired = |exp_arr;
    end

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WW-1:CW] == '0);
    assert_refuse_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_REFUSE) |=> priv_fault);
    assert_refuse_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_REFUSE && wr_sel == SEL_IVT)
            |=> (cnt_arr[1] == $past(cnt_arr[1]) + 1'b1));
    assert_other_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_IDLE && wr_sel == SEL_TOD)
            |=> (cnt_arr[1] == $past(cnt_arr[1]) + 1'b1));
    assert_tod_no_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_arr[0] && !(&cnt_arr[1])) |=> !timer_expired);
endmodule

// File: tb/tb_chrono_regs.sv
module tb_chrono_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, wr_high = 1'b0, wr_kernel = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [63:0] rd_data;
    logic [31:0] rd_high_word;
    logic        priv_fault, timer_expired;

    int errors = 0;
    int checks = 0;
    logic [63:0] prev_t, prev_i;
    localparam logic [53:0] ONES = '1;

    always #4 clk = ~clk;

    chrono_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_high(wr_high),
        .wr_kernel(wr_kernel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .rd_high_word(rd_high_word), .priv_fault(priv_fault), .timer_expired(timer_expired)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [63:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    // write applied at the next edge; returns at the negedge after that edge
    task automatic wr(input logic sel, input logic kern, input logic high, input logic [63:0] d);
        @(negedge clk);
        rd(1'b0, prev_t);
        rd(1'b1, prev_i);
        wr_en = 1'b1; wr_sel = sel; wr_kernel = kern; wr_high = high; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [63:0] v;
        rd(1'b0, v); chk("R1 tod reset", v, 64'd0);
        rd(1'b1, v); chk("R1 ivt reset", v, 64'd0);
        chk("R1 fault reset", {63'd0, priv_fault}, 64'd0);
        chk("R1 expiry reset", {63'd0, timer_expired}, 64'd0);
    endtask

    task automatic t_count;
        logic [63:0] a, b, c;
        @(negedge clk);
        rd(1'b0, a); rd(1'b1, c);
        chk("R2 counters together", c, a);
        @(negedge clk);
        rd(1'b0, b); chk("R2 tod step", b, a + 1);
        rd(1'b1, b); chk("R2 ivt step", b, c + 1);
    endtask

    task automatic t_read_format;
        logic [63:0] v;
        wr(1'b0, 1'b1, 1'b0, {10'h3FF, 54'h2A_5555_0F0F_1234});
        rd(1'b0, v);
        chk("R3 upper bits zero, R4 load", v, {10'd0, 54'h2A_5555_0F0F_1234});
        chk("R3 high word port", {32'd0, rd_high_word}, {32'd0, v[63:32]});
    endtask

    task automatic t_kernel_full;
        logic [63:0] v;
        wr(1'b1, 1'b1, 1'b0, 64'h0012_3456_789A_BCDE);
        rd(1'b1, v); chk("R4 ivt full load", v, 64'h0012_3456_789A_BCDE);
        @(negedge clk);
        rd(1'b1, v); chk("R4 counts on after load", v, 64'h0012_3456_789A_BCDF);
    endtask

    task automatic t_kernel_high;
        logic [63:0] v;
        wr(1'b0, 1'b1, 1'b1, {10'h2AB, 22'h1F_0F0F, 32'hDEAD_BEEF});
        rd(1'b0, v);
        chk("R5 high word write", v, {10'd0, 22'h1F_0F0F, prev_t[31:0]});
    endtask

    task automatic t_user_refused;
        logic [63:0] v;
        wr(1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0007);
        rd(1'b1, v); chk("R6 user full refused", v, prev_i + 1);
        chk("R6 fault pulse", {63'd0, priv_fault}, 64'd1);
        @(negedge clk);
        chk("R6 fault single cycle", {63'd0, priv_fault}, 64'd0);
        wr(1'b0, 1'b0, 1'b1, 64'h003F_FFFF_0000_0000);
        rd(1'b0, v); chk("R6 user high refused", v, prev_t + 1);
        chk("R6 fault pulse high", {63'd0, priv_fault}, 64'd1);
    endtask

    task automatic t_target_only;
        logic [63:0] v;
        wr(1'b0, 1'b1, 1'b0, 64'h55);
        rd(1'b1, v); chk("R7 ivt unaffected by tod write", v, prev_i + 1);
        wr(1'b1, 1'b1, 1'b0, 64'h77);
        rd(1'b0, v); chk("R7 tod unaffected by ivt write", v, prev_t + 1);
    endtask

    task automatic t_expiry;
        logic [63:0] v;
        wr(1'b1, 1'b1, 1'b0, {10'd0, ONES});
        chk("R8 no pulse at all-ones", {63'd0, timer_expired}, 64'd0);
        @(negedge clk);
        rd(1'b1, v); chk("R8 wrapped to zero", v, 64'd0);
        chk("R8 expiry pulse", {63'd0, timer_expired}, 64'd1);
        @(negedge clk);
        chk("R8 pulse single cycle", {63'd0, timer_expired}, 64'd0);
    endtask

    task automatic t_zero_load;
        logic [63:0] v;
        wr(1'b1, 1'b1, 1'b0, 64'd0);
        chk("R9 zero load no pulse", {63'd0, timer_expired}, 64'd0);
        @(negedge clk);
        chk("R9 zero load no later pulse", {63'd0, timer_expired}, 64'd0);
        wr(1'b1, 1'b1, 1'b0, {10'd0, ONES - 54'd1});
        wr(1'b1, 1'b1, 1'b0, 64'd5);
        chk("R9 load wins over wrap, setup at all-ones", prev_i, {10'd0, ONES});
        rd(1'b1, v); chk("R9 loaded value", v, 64'd5);
        chk("R9 no pulse when load replaces wrap", {63'd0, timer_expired}, 64'd0);
    endtask

    task automatic t_tod_wrap;
        logic [63:0] v;
        wr(1'b0, 1'b1, 1'b0, {10'd0, ONES});
        @(negedge clk);
        rd(1'b0, v); chk("R10 tod wrapped", v, 64'd0);
        chk("R10 no expiry from tod", {63'd0, timer_expired}, 64'd0);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2;
        t_reset();
        #20;
        @(negedge clk);
        rst_n = 1'b1;
        t_count();
        t_read_format();
        t_kernel_full();
        t_kernel_high();
        t_user_refused();
        t_target_only();
        t_expiry();
        t_zero_load();
        t_tod_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule